// File: doc/BRIEF.md
# Pixel Gain Steering Sequencer

This block picks, for every pixel of an image sensor readout, one of four stored 6-bit gain codes. It registers the line sync and frame sync inputs on the pixel clock. From the sampled levels and their edge history it produces a 2-bit gain index and the gain word that index selects. The index follows a colour mosaic pattern along a line and from line to line.

Two steering modes run a sequence. In field mode, the frame sync edge seen last before a line sync rising edge chooses the gain pair for the line: gains 0/1 or gains 2/3. In mosaic mode, a frame sync rising edge restarts a pattern in which lines alternate between a 0/1 line and a 1/2 line. A third mode takes the index directly from the two sampled sync levels. Within a line the index stays on the pair's first gain while line sync is high. After line sync falls it alternates on every pixel clock. An enable forces gain 0 when it is low. The edge history keeps updating while the enable is low.

Top module: `pixel_gain_steer`

## Requirements
- R1: After reset, gain_idx_o is 0 and gain_o carries gain word 0. The first line after reset uses the 0/1 alternation in both field mode and mosaic mode.
- R2: hd_i, vd_i and en_i are registered on the rising clock edge, so a change becomes visible at the outputs one clock later and not before.
- R3: In field mode (mode_i = 0), a line sync rising edge whose most recent preceding frame sync edge was rising starts a 2,3,2,3 line.
- R4: In field mode, a line sync rising edge whose most recent preceding frame sync edge was falling starts a 0,1,0,1 line.
- R5: In field mode, a line sync rising edge with no frame sync edge since the previous line sync rising edge keeps the pair of the previous line.
- R6: In mosaic mode (mode_i = 1), a line sync rising edge preceded by a frame sync rising edge starts a 0,1,0,1 line.
- R7: In mosaic mode, each line sync rising edge without a new frame sync rising edge swaps the line between 0,1 and 1,2. A frame sync falling edge has no effect, and index 3 never appears.
- R8: In direct mode (mode_i = 2 or 3), the index is {sampled vd, sampled hd}: 00 gives 0, 01 gives 1, 10 gives 2, 11 gives 3.
- R9: While sampled line sync is high, the sequenced index stays on the first gain of the line. On the first clock after it falls the index is still the first gain, and it then toggles on every clock.
- R10: With en_i low, gain_idx_o is 0. The edge history still advances, so after re-enabling, the line pair reflects the sync edges seen while disabled.
- R11: gain_o equals gain word k of gains_i, taken from bits [6k+5:6k], where k is gain_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Line sync |
| vd_i | input | 1 | Frame sync |
| mode_i | input | 2 | 0 field pairs, 1 mosaic repeat, 2/3 direct from sync levels |
| en_i | input | 1 | Steering enable; low forces index 0 |
| gains_i | input | 24 | Four 6-bit gain words, word k at bits [6k+5:6k] |
| gain_idx_o | output | 2 | Selected gain index |
| gain_o | output | 6 | Selected gain word |

## Verification
A wrong edge-history flag does not show while the current line runs. It appears only after the next line sync rising edge, one clock after the registered rise, as the wrong pair on every pixel of that line. The bench therefore checks whole lines after each frame sync change, and also the line after one with no change. A wrong pixel phase shows within one clock after line sync falls, as an index that does not alternate. A wrong sample stage shows in direct mode as an index that moves in the same cycle as its inputs, or one cycle late.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    MODE_FIELD  = 2'd0,
    MODE_MOSAIC = 2'd1,
    MODE_DIRECT = 2'd2,
    MODE_DIR_B  = 2'd3
  } steer_mode_e;
endpackage

// File: rtl/pgs_sync_edge.sv
module pgs_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hd_i,
  input  logic vd_i,
  input  logic en_i,
  output logic hd_q_o,
  output logic vd_q_o,
  output logic en_q_o,
  output logic hd_rise_o,
  output logic vd_rise_o,
  output logic vd_fall_o
);
  logic hd_d, vd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q_o <= 1'b0;
      vd_q_o <= 1'b0;
      en_q_o <= 1'b0;
      hd_d   <= 1'b0;
      vd_d   <= 1'b0;
    end else begin
      hd_q_o <= hd_i;
      vd_q_o <= vd_i;
      en_q_o <= en_i;
      hd_d   <= hd_q_o;
      vd_d   <= vd_q_o;
    end
  end

  assign hd_rise_o = hd_q_o & ~hd_d;
  assign vd_rise_o = vd_q_o & ~vd_d;
  assign vd_fall_o = ~vd_q_o & vd_d;
endmodule

// File: rtl/pgs_line_seq.sv
module pgs_line_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hd_q_i,
  input  logic hd_rise_i,
  input  logic vd_rise_i,
  input  logic vd_fall_i,
  output logic phase_o,
  output logic field_hi_o,
  output logic mosaic_hi_o
);
  logic rise_seen, fall_seen, last_rise, line_seen;
  logic any_rise, any_edge, newest_rise;

  // edges coincident with the line rise still count toward its decision
  assign any_rise    = rise_seen | vd_rise_i;
  assign any_edge    = rise_seen | fall_seen | vd_rise_i | vd_fall_i;
  assign newest_rise = vd_rise_i ? 1'b1 : (vd_fall_i ? 1'b0 : last_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o     <= 1'b0;
      field_hi_o  <= 1'b0;
      mosaic_hi_o <= 1'b0;
      rise_seen   <= 1'b0;
      fall_seen   <= 1'b0;
      last_rise   <= 1'b0;
      line_seen   <= 1'b0;
    end else begin
      phase_o <= hd_q_i ? 1'b0 : ~phase_o;
      if (vd_rise_i || vd_fall_i) last_rise <= vd_rise_i;
      if (hd_rise_i) begin
        rise_seen <= 1'b0;
        fall_seen <= 1'b0;
        line_seen <= 1'b1;
        if (any_edge) field_hi_o <= newest_rise;
        mosaic_hi_o <= (any_rise || !line_seen) ? 1'b0 : ~mosaic_hi_o;
      end else begin
        if (vd_rise_i) rise_seen <= 1'b1;
        if (vd_fall_i) fall_seen <= 1'b1;
      end
    end
  end

  assert_hd_holds_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hd_q_i) |-> !phase_o);

  assert_history_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hd_rise_i) |-> (!rise_seen && !fall_seen));

  assert_mosaic_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hd_rise_i && (rise_seen || vd_rise_i)) |-> !mosaic_hi_o);
endmodule

// File: rtl/pgs_gain_mux.sv
module pgs_gain_mux #(
  parameter int GAIN_W    = 6,
  parameter int NUM_GAINS = 4,
  localparam int IDX_W    = $clog2(NUM_GAINS)
) (
  input  logic [NUM_GAINS*GAIN_W-1:0] gains_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [GAIN_W-1:0]           gain_o
);
  logic [GAIN_W-1:0] words [NUM_GAINS];

  for (genvar k = 0; k < NUM_GAINS; k++) begin : g_word
    assign words[k] = gains_i[k*GAIN_W +: GAIN_W];
  end

  assign gain_o = words[idx_i];
endmodule

// File: rtl/pixel_gain_steer.sv
module pixel_gain_steer
  import pgs_pkg::*;
#(
  parameter int GAIN_W    = 6,
  parameter int NUM_GAINS = 4,
  localparam int IDX_W    = $clog2(NUM_GAINS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        hd_i,
  input  logic                        vd_i,
  input  logic [1:0]                  mode_i,
  input  logic                        en_i,
  input  logic [NUM_GAINS*GAIN_W-1:0] gains_i,
  output logic [IDX_W-1:0]            gain_idx_o,
  output logic [GAIN_W-1:0]           gain_o
);
  steer_mode_e mode;
  logic hd_q, vd_q, en_q, hd_rise, vd_rise, vd_fall;
  logic phase, field_hi, mosaic_hi;
  logic [IDX_W-1:0] idx_sel;

  assign mode = steer_mode_e'(mode_i);

  pgs_sync_edge i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hd_i      (hd_i),
    .vd_i      (vd_i),
    .en_i      (en_i),
    .hd_q_o    (hd_q),
    .vd_q_o    (vd_q),
    .en_q_o    (en_q),
    .hd_rise_o (hd_rise),
    .vd_rise_o (vd_rise),
    .vd_fall_o (vd_fall)
  );

  pgs_line_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hd_q_i      (hd_q),
    .hd_rise_i   (hd_rise),
    .vd_rise_i   (vd_rise),
    .vd_fall_i   (vd_fall),
    .phase_o     (phase),
    .field_hi_o  (field_hi),
    .mosaic_hi_o (mosaic_hi)
  );

  always_comb begin
    unique case (mode)
      MODE_FIELD:  idx_sel = IDX_W'({field_hi, phase});
      MODE_MOSAIC: idx_sel = IDX_W'({1'b0, phase}) + IDX_W'(mosaic_hi);
      default:     idx_sel = IDX_W'({vd_q, hd_q});
    endcase
  end

  assign gain_idx_o = en_q ? idx_sel : '0;

  pgs_gain_mux #(
    .GAIN_W    (GAIN_W),
    .NUM_GAINS (NUM_GAINS)
  ) i_mux (
    .gains_i (gains_i),
    .idx_i   (gain_idx_o),
    .gain_o  (gain_o)
  );

  assert_disabled_gain0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(en_i)) |-> (gain_idx_o == '0 && gain_o == gains_i[GAIN_W-1:0]));

  assert_direct_levels_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_i[1] && $past(en_i)) |-> gain_idx_o == IDX_W'({$past(vd_i), $past(hd_i)}));

  assert_mosaic_no_gain3_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |-> gain_idx_o != IDX_W'(3));
endmodule

// File: tb/test_pixel_gain_steer.sv
module test_pixel_gain_steer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd = 1'b0, vd = 1'b0, en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [23:0] gains = {6'h3F, 6'h2C, 6'h1A, 6'h05};
  logic [1:0] idx;
  logic [5:0] gw;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_gain_steer i_pixel_gain_steer (
    .clk_i (clk), .rst_ni (rst_n), .hd_i (hd), .vd_i (vd),
    .mode_i (mode), .en_i (en), .gains_i (gains),
    .gain_idx_o (idx), .gain_o (gw)
  );

  function automatic logic [5:0] word_of(int k);
    return gains[k*6 +: 6];
  endfunction

  task automatic check(string req, int exp);
    n_tests++;
    if (idx !== 2'(exp) || gw !== word_of(exp)) begin
      n_fail++;
      $display("FAIL %s: idx=%0d gain=%h, expected idx=%0d gain=%h", req, idx, gw, exp, word_of(exp));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hd = 1'b0; vd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // line sync high for 5 clocks, then npix pixels alternating a, b
  task automatic run_line(string req, int a, int b, int npix);
    @(negedge clk); hd = 1'b1;
    @(negedge clk);
    @(negedge clk); check({req, "/R9 hold"}, a);
    repeat (3) @(negedge clk);
    hd = 1'b0;
    for (int i = 0; i < npix; i++) begin
      @(negedge clk);
      check(req, (i % 2 == 0) ? a : b);
    end
  endtask

  task automatic vd_set(logic v);
    @(negedge clk); vd = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk); check("R1 reset", 0);
    en = 1'b1;
    #1 check("R2 enable not yet sampled", 0);
    @(negedge clk); check("R1 enabled idle", 0);
  endtask

  task automatic t_field();
    mode = 2'd0;
    run_line("R1 field first line", 0, 1, 4);
    vd_set(1'b1);
    run_line("R3", 2, 3, 4);
    run_line("R5 odd repeat", 2, 3, 4);
    vd_set(1'b0);
    run_line("R4", 0, 1, 4);
    run_line("R5 even repeat", 0, 1, 3);
  endtask

  task automatic t_mosaic();
    do_reset();
    mode = 2'd1;
    run_line("R1 mosaic first line", 0, 1, 4);
    run_line("R7 swap", 1, 2, 4);
    run_line("R7 swap back", 0, 1, 4);
    vd_set(1'b1);
    run_line("R6", 0, 1, 4);
    vd_set(1'b0);
    run_line("R7 fall ignored", 1, 2, 4);
    run_line("R7 next", 0, 1, 3);
  endtask

  task automatic t_direct();
    int prev;
    mode = 2'd2;
    @(negedge clk); hd = 1'b0; vd = 1'b0;
    @(negedge clk); check("R8 00", 0);
    prev = 0;
    for (int c = 3; c >= 0; c--) begin
      @(negedge clk);
      if (c == 1) mode = 2'd3;
      vd = c[1]; hd = c[0];
      #1 check("R2 not before edge", prev);
      @(negedge clk); check("R8", c);
      prev = c;
    end
  endtask

  task automatic t_disable();
    do_reset();
    mode = 2'd0;
    @(negedge clk); en = 1'b0;
    @(negedge clk); check("R10 disabled", 0);
    vd_set(1'b1);
    run_line("R10 disabled line", 0, 0, 4);
    en = 1'b1;
    run_line("R10 history kept", 2, 3, 4);
  endtask

  task automatic t_word();
    mode = 2'd2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); vd = k[1]; hd = k[0];
      @(negedge clk); check("R11 word", k);
    end
  endtask

  initial begin
    t_reset();
    t_field();
    t_mosaic();
    t_direct();
    t_disable();
    t_word();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1: actual=still running, expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule